// File: doc/BRIEF.md
# ATM Cell Transmit Processor

This block sits between a transmit cell FIFO and a downstream framer. It takes 53-byte cells one byte per cycle, with a marker on the first byte, and sends out a continuous stream of cells under a valid/ready handshake. For each cell it can generate the header check byte (a CRC-8 over the first four header bytes) and write it into the fifth byte. It can XOR a fixed coset pattern into that byte. It can also scramble the 48 payload bytes with a self-synchronizing scrambler whose state carries on from one cell to the next.

When no cell is waiting at a cell boundary, the block makes a fill cell of its own. The fill cell is either idle or unassigned, chosen by a setting. For diagnostics, the check byte of selected cells can be corrupted in a single-bit or a multi-bit pattern, at a programmable rate and for a programmable number of cells. A counter records how many cells were taken from the FIFO.

Top module: `atx_cell_tx`

## Requirements
- R1: A cell starts when a byte with `in_soc`=1 is offered while the output is at a cell boundary. Its header bytes 1-4 are forwarded unchanged, and with the scrambler off its payload bytes 6-53 are forwarded unchanged. `in_soc` on any later byte of the cell is ignored.
- R2: With `cfg_hec_en`=1, output byte 5 of a FIFO cell is the CRC-8 of output bytes 1-4. The CRC uses generator x^8+x^2+x+1 (0x07), initial value 0, and processes each byte most significant bit first. With `cfg_hec_en`=0, input byte 5 is forwarded unchanged.
- R3: Whenever byte 5 is generated and `cfg_coset_en`=1, the value 0x55 is XORed into it.
- R4: With `cfg_scr_en`=1, bytes 6-53 of every cell, fill cells included, are scrambled most significant bit first: out = in XOR (the output bit sent 43 bits earlier). Header bytes are never scrambled. The scrambler state starts at zero after reset, carries across cells, and is frozen while `cfg_scr_en`=0.
- R5: If no start-of-cell byte is offered at a boundary, a fill cell is sent. With `cfg_fill_sel`=0 it is idle (header 00 00 00 01); with `cfg_fill_sel`=1 it is unassigned (header 00 00 00 00). Every payload byte of a fill cell is 0x6A. Byte 5 of a fill cell is always generated (R2, R3), whatever `cfg_hec_en` is.
- R6: A byte offered at a boundary with `in_soc`=0 is consumed and dropped, and a fill cell is sent in that slot.
- R7: While `cfg_err_en`=1, every N-th FIFO cell (N=`cfg_err_rate`, where 0 counts as 1) has byte 5 XORed with 0x01 when `cfg_err_multi`=0, or with 0x0F when `cfg_err_multi`=1. This stops after `cfg_err_count` cells have been corrupted. While `cfg_err_en`=0 the rate and count progress is cleared. Fill cells are never corrupted.
- R8: `cell_count` is zero after reset and rises by one for each FIFO cell, when its first byte is accepted.
- R9: `out_valid` is always 1 during a fill cell and at a boundary. Inside a FIFO cell it follows `in_valid`. `in_ready` is never 1 while `out_ready` is 0, and it is 0 during the rest of a fill cell. `out_soc` is 1 on byte 1 of each output cell.
- R10: Synchronous reset puts the output at a cell boundary (`out_valid`=1, `out_soc`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hec_en | input | 1 | Generate byte 5 of FIFO cells |
| cfg_coset_en | input | 1 | XOR 0x55 into a generated byte 5 |
| cfg_scr_en | input | 1 | Scramble payload bytes |
| cfg_fill_sel | input | 1 | Fill cell kind: 0 idle, 1 unassigned |
| cfg_err_en | input | 1 | Enable header error injection |
| cfg_err_multi | input | 1 | 0 single-bit (0x01), 1 multi-bit (0x0F) |
| cfg_err_rate | input | RATE_W | One corrupted cell every N FIFO cells |
| cfg_err_count | input | COUNT_W | Number of cells to corrupt |
| in_valid | input | 1 | FIFO byte available |
| in_ready | output | 1 | FIFO byte taken |
| in_data | input | 8 | FIFO byte |
| in_soc | input | 1 | First byte of a cell |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Processed byte |
| out_soc | output | 1 | First byte of an output cell |
| cell_count | output | CNT_W | Cells read from the FIFO |

## Verification
Cells are sent with all-zero, all-one and mixed headers, so the check byte is tested on more than a constant. Each cell is also sent with the coset off and on, and with generation off, which separates a generated byte 5 from a forwarded one. Scrambled runs mix FIFO cells and fill cells and turn the scrambler off and on again; this shows that the state carries across cells and is held while disabled. Error runs with rate 3 and rate 1 include a fill cell in the middle, which shows the spacing, the cap and the fill exemption. A stray non-start byte, a misplaced start marker and random output backpressure test the alignment and handshake rules.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 4;
    localparam int HEC_POS    = 4;
    localparam int IDX_W      = $clog2(CELL_BYTES);
    localparam int SCR_W      = 43;

    localparam logic [7:0] COSET_PAT    = 8'h55;
    localparam logic [7:0] FILL_PAYLOAD = 8'h6A;
    localparam logic [7:0] ERR_SINGLE   = 8'h01;
    localparam logic [7:0] ERR_MULTI    = 8'h0F;
    localparam logic [7:0] CRC_POLY     = 8'h07;

    typedef enum logic {
        FILL_IDLE       = 1'b0,
        FILL_UNASSIGNED = 1'b1
    } fill_kind_e;

    typedef struct packed {
        logic       hec_en;
        logic       coset_en;
        logic       scr_en;
        fill_kind_e fill;
    } tx_cfg_t;

    typedef struct packed {
        logic [SCR_W-1:0] state;
        logic [7:0]       dout;
    } scr_res_t;

    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] b);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ b[i];
            c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
        end
        return c;
    endfunction

    function automatic scr_res_t scramble_byte(input logic [SCR_W-1:0] st_in, input logic [7:0] b);
        scr_res_t r;
        logic     y;
        r.state = st_in;
        r.dout  = '0;
        for (int i = 7; i >= 0; i--) begin
            y         = b[i] ^ r.state[SCR_W-1];
            r.dout[i] = y;
            r.state   = {r.state[SCR_W-2:0], y};
        end
        return r;
    endfunction
endpackage

// File: rtl/atx_hec_gen.sv
module atx_hec_gen
    import atx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       first,
    input  logic [7:0] din,
    input  logic       coset_en,
    output logic [7:0] hec
);
    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= '0;
        else if (load)
            crc_q <= crc8_byte(first ? 8'h00 : crc_q, din);
    end

    assign hec = crc_q ^ (coset_en ? COSET_PAT : 8'h00);

    // R2: the accumulator only moves on header bytes
    p_hec_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(crc_q));
endmodule

// File: rtl/atx_scrambler.sv
module atx_scrambler
    import atx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [SCR_W-1:0] state_q;
    scr_res_t         res;

    assign res  = scramble_byte(state_q, din);
    assign dout = res.dout;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else if (adv)
            state_q <= res.state;
    end

    // R4: state frozen whenever no payload byte is scrambled
    p_scr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q));
endmodule

// File: rtl/atx_err_ctrl.sv
module atx_err_ctrl
    import atx_pkg::*;
#(
    parameter int RATE_W  = 8,
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               multi,
    input  logic [RATE_W-1:0]  rate,
    input  logic [COUNT_W-1:0] count,
    input  logic               cell_start,
    output logic [7:0]         mask
);
    logic [RATE_W-1:0]  gap_q;
    logic [COUNT_W-1:0] done_q;
    logic               flag_q;
    logic [RATE_W:0]    rate_eff;
    logic [RATE_W:0]    gap_inc;
    logic               room;

    assign rate_eff = (rate == '0) ? {{RATE_W{1'b0}}, 1'b1} : {1'b0, rate};
    assign gap_inc  = {1'b0, gap_q} + 1'b1;
    assign room     = done_q < count;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gap_q  <= '0;
            done_q <= '0;
            flag_q <= 1'b0;
        end else if (cell_start) begin
            if (room && gap_inc >= rate_eff) begin
                flag_q <= 1'b1;
                gap_q  <= '0;
                done_q <= done_q + 1'b1;
            end else if (room) begin
                flag_q <= 1'b0;
                gap_q  <= gap_inc[RATE_W-1:0];
            end else begin
                flag_q <= 1'b0;
            end
        end
    end

    assign mask = flag_q ? (multi ? ERR_MULTI : ERR_SINGLE) : 8'h00;

    // R7: once the programmed count is used up no further cell is marked
    p_err_cap_r7: assert property (@(posedge clk) disable iff (rst)
        (cell_start && en && !room) |=> !flag_q);
endmodule

// File: rtl/atx_cell_tx.sv
module atx_cell_tx
    import atx_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RATE_W  = 8,
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_hec_en,
    input  logic               cfg_coset_en,
    input  logic               cfg_scr_en,
    input  logic               cfg_fill_sel,
    input  logic               cfg_err_en,
    input  logic               cfg_err_multi,
    input  logic [RATE_W-1:0]  cfg_err_rate,
    input  logic [COUNT_W-1:0] cfg_err_count,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_data,
    input  logic               in_soc,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_soc,
    output logic [CNT_W-1:0]   cell_count
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
    localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HEC_POS);

    tx_cfg_t          cfg;
    logic [IDX_W-1:0] idx_q;
    logic             is_data_q;
    logic [CNT_W-1:0] cnt_q;

    logic             at_bound, cur_data, fire, data_start;
    logic             in_hdr, in_pay;
    logic [7:0]       fill_hdr, hdr_byte, pay_base, scr_out, hec_val, err_mask;

    assign cfg.hec_en   = cfg_hec_en;
    assign cfg.coset_en = cfg_coset_en;
    assign cfg.scr_en   = cfg_scr_en;
    assign cfg.fill     = fill_kind_e'(cfg_fill_sel);

    assign at_bound   = (idx_q == '0);
    assign cur_data   = at_bound ? (in_valid && in_soc) : is_data_q;
    assign out_valid  = at_bound ? 1'b1 : (is_data_q ? in_valid : 1'b1);
    assign in_ready   = out_ready && (at_bound || is_data_q);
    assign fire       = out_valid && out_ready;
    assign data_start = fire && at_bound && in_valid && in_soc;
    assign out_soc    = at_bound;
    assign in_hdr     = idx_q < IDX_W'(HDR_BYTES);
    assign in_pay     = idx_q > HEC_IDX;

    // Fill header: only the last header byte differs between kinds
    assign fill_hdr = (idx_q == IDX_W'(HDR_BYTES - 1) && cfg.fill == FILL_IDLE) ? 8'h01 : 8'h00;
    assign hdr_byte = cur_data ? in_data : fill_hdr;
    assign pay_base = cur_data ? in_data : FILL_PAYLOAD;

    atx_hec_gen u_hec (
        .clk      (clk),
        .rst      (rst),
        .load     (fire && in_hdr),
        .first    (at_bound),
        .din      (hdr_byte),
        .coset_en (cfg.coset_en),
        .hec      (hec_val)
    );

    atx_scrambler u_scr (
        .clk  (clk),
        .rst  (rst),
        .adv  (fire && in_pay && cfg.scr_en),
        .din  (pay_base),
        .dout (scr_out)
    );

    atx_err_ctrl #(.RATE_W(RATE_W), .COUNT_W(COUNT_W)) u_err (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_err_en),
        .multi      (cfg_err_multi),
        .rate       (cfg_err_rate),
        .count      (cfg_err_count),
        .cell_start (data_start),
        .mask       (err_mask)
    );

    always_comb begin
        if (in_hdr)
            out_data = hdr_byte;
        else if (idx_q == HEC_IDX)
            out_data = ((!cur_data || cfg.hec_en) ? hec_val : in_data)
                       ^ (cur_data ? err_mask : 8'h00);
        else
            out_data = cfg.scr_en ? scr_out : pay_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            is_data_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            if (fire) begin
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                if (at_bound)
                    is_data_q <= cur_data;
            end
            if (data_start)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cell_count = cnt_q;

    // R8: one increment per accepted cell start
    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        data_start |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R9: the byte after a cell's last byte opens a new cell
    p_soc_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && idx_q == LAST_IDX) |=> out_soc);
    // R6: a slot started without a marker takes no more FIFO bytes
    p_fill_no_take_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && at_bound && !(in_valid && in_soc)) |=> !in_ready);
endmodule

// File: tb/sim_atx_cell_tx.sv
module sim_atx_cell_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_hec_en = 1'b1, cfg_coset_en = 1'b0, cfg_scr_en = 1'b0, cfg_fill_sel = 1'b0;
    logic       cfg_err_en = 1'b0, cfg_err_multi = 1'b0;
    logic [7:0] cfg_err_rate = 8'd1, cfg_err_count = 8'd0;
    logic       in_valid = 1'b0, in_soc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, out_soc;
    logic [7:0] out_data;
    logic [31:0] cell_count;
    logic       out_ready;
    logic       pause = 1'b1, bp_on = 1'b0, bp_bit = 1'b1;

    int tests = 0, fails = 0, data_cells = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic [42:0] m_hist = '0;   // m_hist[0] is the oldest output bit
    int m_gap = 0, m_done = 0;

    always #2 clk = ~clk;
    assign out_ready = !pause && (!bp_on || bp_bit);

    atx_cell_tx u0 (
        .clk(clk), .rst(rst), .cfg_hec_en(cfg_hec_en), .cfg_coset_en(cfg_coset_en),
        .cfg_scr_en(cfg_scr_en), .cfg_fill_sel(cfg_fill_sel), .cfg_err_en(cfg_err_en),
        .cfg_err_multi(cfg_err_multi), .cfg_err_rate(cfg_err_rate), .cfg_err_count(cfg_err_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_soc(in_soc),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_soc(out_soc),
        .cell_count(cell_count));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_crc(input logic [31:0] h);
        logic [8:0] r = '0;
        for (int i = 31; i >= 0; i--) begin
            r = {r[7:0], h[i]};
            if (r[8]) r = r ^ 9'h107;
        end
        for (int i = 0; i < 8; i++) begin
            r = {r[7:0], 1'b0};
            if (r[8]) r = r ^ 9'h107;
        end
        return r[7:0];
    endfunction

    task automatic m_scr(input logic [7:0] d, output logic [7:0] y);
        for (int i = 7; i >= 0; i--) begin
            y[i]   = d[i] ^ m_hist[0];
            m_hist = {y[i], m_hist[42:1]};
        end
    endtask

    task automatic push_exp(input logic [7:0] b, input logic soc, input string req);
        exp_q.push_back({soc, b});
        tag_q.push_back(req);
    endtask

    // expected payload and check byte (R2 R3 R4)
    task automatic push_cell(input logic [31:0] hdr, input logic [7:0] b5, input logic [7:0] pay[48],
                             input logic is_data, input string req);
        logic [7:0] y;
        logic [7:0] hb;
        int rate_eff;
        for (int i = 0; i < 4; i++) push_exp(hdr[31-8*i -: 8], i == 0, req);
        hb = (!is_data || cfg_hec_en) ? (m_crc(hdr) ^ (cfg_coset_en ? 8'h55 : 8'h00)) : b5;
        if (is_data && cfg_err_en && m_done < int'(cfg_err_count)) begin
            rate_eff = (cfg_err_rate == 0) ? 1 : int'(cfg_err_rate);
            m_gap++;
            if (m_gap >= rate_eff) begin
                m_gap = 0; m_done++;
                hb ^= cfg_err_multi ? 8'h0F : 8'h01;
            end
        end
        push_exp(hb, 1'b0, req);
        for (int i = 0; i < 48; i++) begin
            y = pay[i];
            if (cfg_scr_en) m_scr(pay[i], y);
            push_exp(y, 1'b0, req);
        end
    endtask

    task automatic drive_byte(input logic [7:0] d, input logic soc);
        logic ok;
        in_valid = 1'b1; in_data = d; in_soc = soc;
        do begin
            @(negedge clk); ok = in_ready;
            if (!ok) begin @(posedge clk); #1; end
        end while (!ok);
        @(posedge clk); #1;
    endtask

    task automatic send_cell(input logic [31:0] hdr, input logic [7:0] b5, input logic [7:0] seed,
                             input int soc_glitch, input string req);
        logic [7:0] pay[48];
        for (int i = 0; i < 48; i++) pay[i] = seed + 8'(i * 7);
        push_cell(hdr, b5, pay, 1'b1, req);
        data_cells++;
        for (int i = 0; i < 4; i++) drive_byte(hdr[31-8*i -: 8], i == 0);
        drive_byte(b5, 1'b0);
        for (int i = 0; i < 48; i++) drive_byte(pay[i], (i + 5) == soc_glitch);
        in_valid = 1'b0; in_soc = 1'b0;
    endtask

    task automatic wait_fires(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (out_valid && out_ready) k++;
            @(posedge clk); #1;
        end
    endtask

    task automatic push_fill(input string req);
        logic [7:0] pay[48];
        for (int i = 0; i < 48; i++) pay[i] = 8'h6A;
        push_cell(cfg_fill_sel ? 32'h0000_0000 : 32'h0000_0001, 8'h00, pay, 1'b0, req);
    endtask

    task automatic send_fill(input string req);
        push_fill(req);
        in_valid = 1'b0;
        wait_fires(53);
    endtask

    task automatic set_err(input logic en, input logic multi, input logic [7:0] rate, input logic [7:0] cnt);
        pause = 1'b1; cfg_err_en = 1'b0;
        @(posedge clk); #1; @(posedge clk); #1;
        cfg_err_multi = multi; cfg_err_rate = rate; cfg_err_count = cnt; cfg_err_en = en;
        m_gap = 0; m_done = 0;
        pause = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected byte", {23'd0, out_soc, out_data}, 32'hFFFF);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check(t, {23'd0, out_soc, out_data}, {23'd0, e});
            end
        end
    end

    always @(posedge clk) begin
        #1 bp_bit = ($urandom % 3) != 0;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R10 out_valid after reset", 32'(out_valid), 1);
        check("R10 out_soc after reset", 32'(out_soc), 1);
        check("R8 count after reset", cell_count, 0);
        check("R9 in_ready held by out_ready", 32'(in_ready), 0);
        @(posedge clk); #1;
        pause = 1'b0;

        // R1 R2: plain cells with varied headers
        send_cell(32'h0000_0000, 8'hEE, 8'h10, -1, "R1/R2 zero header");
        send_cell(32'hFFFF_FFFF, 8'hEE, 8'h55, -1, "R1/R2 ones header");
        send_cell(32'h1234_5678, 8'hEE, 8'hA0, -1, "R1/R2 mixed header");
        send_fill("R5 idle fill");
        // R3 coset
        cfg_coset_en = 1'b1;
        send_cell(32'h1234_5678, 8'hEE, 8'h01, -1, "R3 coset data");
        send_fill("R3 coset fill");
        // R2 generation off forwards byte 5; fill still generated (R5)
        cfg_hec_en = 1'b0;
        send_cell(32'hCAFE_0042, 8'h3C, 8'h22, -1, "R2 forward byte5");
        cfg_fill_sel = 1'b1;
        send_fill("R5 unassigned fill with hec off");
        cfg_hec_en = 1'b1; cfg_coset_en = 1'b0;
        // R4 scrambling across cells and fills
        cfg_scr_en = 1'b1;
        send_cell(32'h0101_0101, 8'h00, 8'h00, -1, "R4 scramble cell a");
        send_fill("R4 scramble fill");
        send_cell(32'h0202_0202, 8'h00, 8'h33, -1, "R4 scramble cell b");
        cfg_scr_en = 1'b0;
        send_cell(32'h0303_0303, 8'h00, 8'h44, -1, "R4 scrambler off");
        cfg_scr_en = 1'b1;
        send_cell(32'h0404_0404, 8'h00, 8'h55, -1, "R4 scrambler resumed");
        cfg_scr_en = 1'b0; cfg_fill_sel = 1'b0;
        // R7 single-bit, every 3rd cell, 2 cells, with a fill in between
        set_err(1'b1, 1'b0, 8'd3, 8'd2);
        for (int i = 0; i < 4; i++) send_cell(32'h0A00_0000 + i, 8'h00, 8'(i), -1, "R7 single rate3");
        send_fill("R7 fill never errored");
        for (int i = 0; i < 4; i++) send_cell(32'h0B00_0000 + i, 8'h00, 8'(i), -1, "R7 single cap");
        // R7 multi-bit, rate 0 counts as 1, count 1
        set_err(1'b1, 1'b1, 8'd0, 8'd1);
        for (int i = 0; i < 3; i++) send_cell(32'h0C00_0000 + i, 8'h00, 8'(i), -1, "R7 multi rate1");
        set_err(1'b0, 1'b0, 8'd1, 8'd0);
        // R6 stray byte at boundary
        push_fill("R6 stray dropped");
        drive_byte(8'hAB, 1'b0);
        in_valid = 1'b0;
        wait_fires(52);
        // R1 marker inside a cell ignored
        send_cell(32'h5A5A_5A5A, 8'h00, 8'h77, 20, "R1 mid-cell marker");
        // R9 backpressure
        bp_on = 1'b1;
        for (int i = 0; i < 3; i++) send_cell(32'h6600_0000 + i, 8'h00, 8'(i * 9), -1, "R9 backpressure");
        send_fill("R9 fill backpressure");
        bp_on = 1'b0;
        pause = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
        check("R8 cells counted", cell_count, data_cells);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule